// File: doc/BRIEF.md
# Write Completion Status Readback

This block forms the read data that a byte-wide nonvolatile memory returns to its host. While no program cycle is running it passes the array read data through unchanged. While the self-timed program cycle is busy, the host can find out when the cycle has finished by reading. The top bit returns the inverse of the top bit of the byte being programmed. The next bit changes value after every read access.

The byte being programmed is captured on the cycle that program start is signalled. The read strobe is built from the chip-select, output-enable and write-enable pins, all active low. It drives the output enable of the data pins directly. A copy of it is synchronised to the block clock, and the end of each read access advances the toggle flip-flop. The array storage and the pad drivers are outside this block.

Top module: `wcs_status_readback`

## Requirements
- R1: `rdOe` is 1 exactly when `weN` is 1, `oeN` is 0 and `ceN` is 0, and is 0 for every other pin combination.
- R2: While `busy` is 0, `rdData` equals `arrayData` on all 8 bits.
- R3: While `busy` is 1, `rdData[7]` is the inverse of bit 7 of the `wrData` byte captured at the most recent `progStart`.
- R4: `wrData` is sampled only on a clock edge where `progStart` is 1. Changes to `wrData` at other times do not alter the `rdData[7]` returned during busy.
- R5: While `busy` is 1, `rdData[6]` read in one access differs from its value in the preceding access. The toggle advances once per completed read, so reads two apart return the same value.
- R6: Within a single read access, `rdData[6]` holds steady during busy, however long the access lasts.
- R7: Read accesses completed while `busy` is 0 do not advance the toggle bit. The next busy read returns the value that follows the last busy read.
- R8: After reset, a busy read with no preceding `progStart` returns 8'h80, because the captured byte and the toggle both reset to 0 and bits 5:0 are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| busy | input | 1 | Program cycle in progress |
| progStart | input | 1 | One-cycle pulse when a program cycle begins |
| wrData | input | 8 | Byte being programmed |
| arrayData | input | 8 | True data read from the array |
| rdData | output | 8 | Read data to the pins |
| rdOe | output | 1 | Pin driver enable; pins are high impedance when 0 |

## Verification
A vector table mixes busy and idle reads. It uses captured bytes with bit 7 both set and clear, and array values that differ from the captured byte. This shows whether the polling bit follows the captured byte rather than the array, and whether idle reads pass the array byte through unaltered. Three consecutive busy reads separate a toggle that alternates from one that is stuck or that flips twice per access. Idle reads placed between busy reads show whether the toggle advances outside busy. A long single access shows whether the toggle moves in the middle of a read.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  parameter int DATA_W = 8;
  localparam int POLL_BIT   = DATA_W - 1;
  localparam int TOGGLE_BIT = DATA_W - 2;
  localparam logic [DATA_W-3:0] FILL_BITS = '0;

  typedef struct packed {
    logic capture;
    logic toggleAdv;
  } wcsStrobes_t;
endpackage

// File: rtl/wcs_ctrl.sv
module wcs_ctrl
  import wcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        busy,
  input  logic        progStart,
  output logic        rdOe,
  output wcsStrobes_t strb
);
  localparam int STAGES = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;
  localparam int MSB = STAGES - 1;

  logic readPin;
  logic [STAGES-1:0] syncQ;
  logic rdPrev;

  assign readPin = weN & ~oeN & ~ceN;
  assign rdOe = readPin;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= readPin;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[STAGES-2:0], readPin};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPrev <= 1'b0;
    else       rdPrev <= syncQ[MSB];
  end

  always_comb begin
    strb.capture   = progStart;
    strb.toggleAdv = busy & rdPrev & ~syncQ[MSB];
  end

  // R7
  idle_no_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !strb.toggleAdv);
endmodule

// File: rtl/wcs_datapath.sv
module wcs_datapath
  import wcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wcsStrobes_t       strb,
  input  logic              busy,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] lastByte;
  logic toggleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastByte <= '0;
      toggleQ  <= 1'b0;
    end else begin
      if (strb.capture)   lastByte <= wrData;
      if (strb.toggleAdv) toggleQ  <= ~toggleQ;
    end
  end

  always_comb begin
    if (busy) rdData = {~lastByte[POLL_BIT], toggleQ, FILL_BITS};
    else      rdData = arrayData;
  end

  // R2
  true_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> rdData == arrayData);
  // R3
  poll_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.capture) && busy) |-> rdData[POLL_BIT] != $past(wrData[POLL_BIT]));
  // R4
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(lastByte));
  // R5
  toggle_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.toggleAdv |=> toggleQ != $past(toggleQ));
  // R6
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.toggleAdv |=> $stable(toggleQ));
endmodule

// File: rtl/wcs_status_readback.sv
module wcs_status_readback
  import wcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  input  logic       busy,
  input  logic       progStart,
  input  logic [7:0] wrData,
  input  logic [7:0] arrayData,
  output logic [7:0] rdData,
  output logic       rdOe
);
  wcsStrobes_t strb;

  wcs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .busy(busy), .progStart(progStart), .rdOe(rdOe), .strb(strb)
  );

  wcs_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .wrData(wrData), .arrayData(arrayData), .rdData(rdData)
  );

  // R1
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN || !weN) |-> !rdOe);
endmodule

// File: tb/wcs_status_readback_bench.sv
module wcs_status_readback_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic busy = 1'b0, progStart = 1'b0;
  logic [7:0] wrData = '0, arrayData = '0;
  logic [7:0] rdData;
  logic rdOe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wcs_status_readback u_wcs_status_readback (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .busy(busy), .progStart(progStart), .wrData(wrData),
    .arrayData(arrayData), .rdData(rdData), .rdOe(rdOe)
  );

  // {start, busy, wrData, arrayData, expected}
  localparam logic [25:0] VEC [6] = '{
    {1'b1, 1'b1, 8'hA5, 8'h3C, 8'h00},
    {1'b0, 1'b1, 8'hFF, 8'h11, 8'h00},
    {1'b0, 1'b0, 8'h00, 8'h3C, 8'h3C},
    {1'b1, 1'b1, 8'h12, 8'hFF, 8'h80},
    {1'b0, 1'b0, 8'h5A, 8'hC3, 8'hC3},
    {1'b1, 1'b1, 8'h80, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic startProg(input logic [7:0] b);
    @(negedge clk);
    wrData = b; progStart = 1'b1; busy = 1'b1;
    @(negedge clk);
    progStart = 1'b0;
  endtask

  task automatic readOnce(input int hold, output logic [7:0] val);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0;
    #1 val = rdData;
    repeat (hold) @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, a, b, c, t;
    repeat (3) @(negedge clk);
    check("R1 reset", {7'd0, rdOe}, 8'h00);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    busy = 1'b1;
    readOnce(2, v);
    check("R8", v, 8'h80);
    busy = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      if (VEC[i][25]) startProg(VEC[i][23:16]);
      else begin
        @(negedge clk);
        wrData = VEC[i][23:16];
        busy = VEC[i][24];
      end
      arrayData = VEC[i][15:8];
      readOnce(2, v);
      if (VEC[i][24]) check("R3 R4 poll", v & 8'h80, VEC[i][7:0]);
      else            check("R2 pass", v, VEC[i][7:0]);
    end

    // R1 pin combinations
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b0; weN = 1'b1; #1 check("R1 ce high", {7'd0, rdOe}, 8'h00);
    ceN = 1'b0; oeN = 1'b1; #1 check("R1 oe high", {7'd0, rdOe}, 8'h00);
    oeN = 1'b0; weN = 1'b0; #1 check("R1 we low", {7'd0, rdOe}, 8'h00);
    weN = 1'b1; #1 check("R1 read", {7'd0, rdOe}, 8'h01);
    ceN = 1'b1; oeN = 1'b1;
    repeat (6) @(negedge clk);

    // R5 alternation
    startProg(8'h00);
    readOnce(2, a); readOnce(2, b); readOnce(2, c);
    check("R5 first pair", {7'd0, a[6] ^ b[6]}, 8'h01);
    check("R5 second pair", {7'd0, b[6] ^ c[6]}, 8'h01);
    check("R5 two apart", {7'd0, a[6]}, {7'd0, c[6]});

    // R6 long access
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0;
    #1 a = rdData;
    repeat (12) @(negedge clk);
    #1 b = rdData;
    check("R6 steady", {7'd0, b[6]}, {7'd0, a[6]});
    ceN = 1'b1; oeN = 1'b1;
    repeat (6) @(negedge clk);

    // R7 idle reads do not advance
    readOnce(2, t);
    busy = 1'b0;
    arrayData = 8'h00;
    readOnce(2, v); readOnce(2, v); readOnce(2, v);
    check("R7 idle data", v, 8'h00);
    @(negedge clk);
    busy = 1'b1;
    readOnce(2, v);
    check("R7 resume", {7'd0, v[6]}, {7'd0, ~t[6]});

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule